// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Selector

This block collects a set of level-type interrupt sources from on-chip peripherals. It synchronises them to the local clock and qualifies each one with a software-controlled enable bit. From the sources that are both active and enabled, it picks one at a time. No source has a fixed priority over another. The search for the next source starts just after the source served most recently, so a busy low-numbered source cannot starve a high-numbered one.

Software reaches the enable register through a small register port. The port can write and read the whole enable word, read back the synchronised source levels, and set or clear a single enable bit by index. A consumer asks for the next source with a one-cycle take strobe. The chosen index and a valid flag are visible combinationally before the strobe. Taking a source acknowledges it by clearing its enable bit, so that source is not offered again until software re-enables it. A registered summary line tells the processor that at least one source is pending.

Top module: `rr_irq_select`

## Requirements
- R1: A source is pending only when its synchronised level and its enable bit are both 1; `pickValid` is high only while `pickIdx` names a pending source.
- R2: With no source pending, `pickValid` stays low and a take strobe has no effect.
- R3: The search begins at the saved pointer and walks upward through the indices, wrapping from NUM_SRC-1 to 0; the first pending index found is offered.
- R4: A take strobe while `pickValid` is high moves the pointer to the offered index plus one, wrapping to 0 after NUM_SRC-1; otherwise the pointer holds.
- R5: A take strobe while `pickValid` is high clears the enable bit of the offered source at that clock edge.
- R6: A single-bit operation (`bitOpEn`, with `bitOpSet` 1 to set and 0 to clear) changes only the enable bit at `bitOpIdx`.
- R7: Register address 0 reads and writes the enable word. Address 1 reads the synchronised levels, and writes to it are ignored. Reads are combinational.
- R8: A change on `srcLevel` becomes visible at address 1 after exactly two rising clock edges.
- R9: `cpuIrq` is the OR of all pending bits, registered, so it follows the pending state one cycle later.
- R10: Reset clears the pointer to 0, the enable word to all zeros, the synchronisers and `cpuIrq`.
- R11: When several updates to the enable word fall in the same cycle, they apply in this order: the full-word write, then the single-bit operation, then the acknowledge clear. The acknowledge clear therefore always wins on its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcLevel | input | NUM_SRC | Raw interrupt levels, one per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 enable word, 1 level view |
| regWrData | input | NUM_SRC | Register write data |
| regRdData | output | NUM_SRC | Register read data for `regAddr` |
| bitOpEn | input | 1 | Single-bit enable operation strobe |
| bitOpSet | input | 1 | 1 sets, 0 clears the addressed enable bit |
| bitOpIdx | input | IDX_W | Index for the single-bit operation |
| takeNext | input | 1 | Take and acknowledge the offered source |
| pickValid | output | 1 | A pending source is offered |
| pickIdx | output | IDX_W | Index of the offered source |
| cpuIrq | output | 1 | Registered summary interrupt |

## Verification
The bench builds the block with its defaults: 32 sources and a two-stage synchroniser. With 32 sources the pointer can sit above the highest pending index, so a pick must wrap past index 31 back to low indices. The bench drives exactly that case. The two-stage depth makes the level-to-status latency a fixed two edges, so the bench can sample the edge before and the edge after the change. A reference model of the enable word and pointer in the bench predicts every offered index and feeds a queue that the monitor drains as takes happen.

// File: rtl/rrsel_pkg.sv
package rrsel_pkg;

  localparam logic REG_MASK   = 1'b0;
  localparam logic REG_STATUS = 1'b1;

  // Strobes from control to datapath, applied to the enable word in field order
  typedef struct packed {
    logic fullWr;
    logic bitSet;
    logic bitClr;
    logic ackClr;
  } maskStrobe_t;

endpackage

// File: rtl/rrsel_ctrl.sv
module rrsel_ctrl
  import rrsel_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic              bitOpEn,
  input  logic              bitOpSet,
  input  logic              takeNext,
  input  logic              pickValid,
  input  logic [IDX_W-1:0]  pickIdx,
  output maskStrobe_t       strb,
  output logic [IDX_W-1:0]  ptrQ
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  logic             takeOk;
  logic [IDX_W-1:0] ptrNext;

  assign takeOk = takeNext && pickValid;

  always_comb begin
    strb.fullWr = regWrEn && (regAddr == REG_MASK);
    strb.bitSet = bitOpEn && bitOpSet;
    strb.bitClr = bitOpEn && !bitOpSet;
    strb.ackClr = takeOk;
  end

  // Pointer lands one past the served index, wrapping at the last source
  always_comb begin
    if (pickIdx == LAST_IDX) ptrNext = '0;
    else                     ptrNext = pickIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptrQ <= '0;
    else if (takeOk) ptrQ <= ptrNext;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptrQ <= LAST_IDX); // R4

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(takeNext && pickValid) |=> $stable(ptrQ)); // R4

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (takeNext && pickValid && pickIdx == LAST_IDX) |=> ptrQ == '0); // R4

endmodule

// File: rtl/rrsel_dp.sv
module rrsel_dp
  import rrsel_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int IDX_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  maskStrobe_t        strb,
  input  logic               regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic [IDX_W-1:0]   bitOpIdx,
  input  logic [IDX_W-1:0]   ptrQ,
  output logic               pickValid,
  output logic [IDX_W-1:0]   pickIdx,
  output logic               cpuIrq
);

  localparam int CAND_W = IDX_W + 1;
  localparam logic [CAND_W-1:0] SRC_CNT = CAND_W'(NUM_SRC);

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] maskD;
  logic [NUM_SRC-1:0] pending;
  logic               pendAny;

  // Level synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= srcLevel;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign statusQ = syncQ[SYNC_STAGES-1];

  // Enable word: full write, then bit op, then acknowledge clear
  always_comb begin
    maskD = maskQ;
    if (strb.fullWr) maskD = regWrData;
    if (strb.bitSet) maskD[bitOpIdx] = 1'b1;
    if (strb.bitClr) maskD[bitOpIdx] = 1'b0;
    if (strb.ackClr) maskD[pickIdx]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) maskQ <= '0;
    else        maskQ <= maskD;
  end

  assign pending = statusQ & maskQ;
  assign pendAny = |pending;

  // Rotating search: lowest offset from the pointer wins
  always_comb begin
    logic [CAND_W-1:0] cand;
    pickValid = 1'b0;
    pickIdx   = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      cand = {1'b0, ptrQ} + CAND_W'(k);
      if (cand >= SRC_CNT) cand = cand - SRC_CNT;
      if (pending[cand[IDX_W-1:0]]) begin
        pickValid = 1'b1;
        pickIdx   = cand[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpuIrq <= 1'b0;
    else        cpuIrq <= pendAny;
  end

  always_comb begin
    if (regAddr == REG_STATUS) regRdData = statusQ;
    else                       regRdData = maskQ;
  end

  AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pickValid |-> (statusQ[pickIdx] && maskQ[pickIdx])); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ & statusQ) == '0 |-> !pickValid); // R2

  AST_ACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ackClr |=> !maskQ[$past(pickIdx)]); // R5

  AST_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.bitSet && !strb.fullWr && !strb.ackClr) |=>
      ($countones(maskQ ^ $past(maskQ)) <= 1)); // R6

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cpuIrq == $past(pendAny)); // R9

endmodule

// File: rtl/rr_irq_select.sv
module rr_irq_select
  import rrsel_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic               bitOpEn,
  input  logic               bitOpSet,
  input  logic [IDX_W-1:0]   bitOpIdx,
  input  logic               takeNext,
  output logic               pickValid,
  output logic [IDX_W-1:0]   pickIdx,
  output logic               cpuIrq
);

  maskStrobe_t      strb;
  logic [IDX_W-1:0] ptrQ;

  rrsel_ctrl #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regAddr(regAddr),
    .bitOpEn(bitOpEn), .bitOpSet(bitOpSet),
    .takeNext(takeNext), .pickValid(pickValid), .pickIdx(pickIdx),
    .strb(strb), .ptrQ(ptrQ)
  );

  rrsel_dp #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .srcLevel(srcLevel), .strb(strb),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .bitOpIdx(bitOpIdx), .ptrQ(ptrQ),
    .pickValid(pickValid), .pickIdx(pickIdx), .cpuIrq(cpuIrq)
  );

endmodule

// File: tb/tb_rr_irq_select.sv
module tb_rr_irq_select;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  srcLevel = '0;
  logic          regWrEn = 1'b0;
  logic          regAddr = 1'b0;
  logic [N-1:0]  regWrData = '0;
  logic [N-1:0]  regRdData;
  logic          bitOpEn = 1'b0;
  logic          bitOpSet = 1'b0;
  logic [4:0]    bitOpIdx = '0;
  logic          takeNext = 1'b0;
  logic          pickValid;
  logic [4:0]    pickIdx;
  logic          cpuIrq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;
  int expQ[$];

  logic [N-1:0] mMask = '0;
  int           mPtr = 0;

  always #4 clk = ~clk;

  rr_irq_select dut (
    .clk(clk), .rst_n(rst_n), .srcLevel(srcLevel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .bitOpEn(bitOpEn), .bitOpSet(bitOpSet), .bitOpIdx(bitOpIdx),
    .takeNext(takeNext), .pickValid(pickValid), .pickIdx(pickIdx), .cpuIrq(cpuIrq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int modelPick();
    logic [N-1:0] pend = srcLevel & mMask;
    for (int k = 0; k < N; k++) begin
      if (pend[(mPtr + k) % N]) return (mPtr + k) % N;
    end
    return -1;
  endfunction

  // Monitor: pops the expected index on every accepted take
  always @(negedge clk) begin
    if (rst_n && takeNext && pickValid) begin
      if (expQ.size() == 0) chk("R3 unexpected pick", {27'd0, pickIdx}, 32'hFFFF_FFFF);
      else chk("R3 pick order", {27'd0, pickIdx}, 32'(expQ.pop_front()));
    end
  end

  task automatic takeOne();
    int e = modelPick();
    if (e >= 0) expQ.push_back(e);
    else begin
      @(negedge clk);
      chk("R2 idle valid", {31'd0, pickValid}, 0);
      @(posedge clk); #1;
    end
    takeNext = 1'b1;
    tick(1);
    takeNext = 1'b0;
    if (e >= 0) begin
      mMask[e] = 1'b0;
      mPtr = (e + 1) % N;
    end
  endtask

  task automatic regWrite(logic a, logic [N-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
    if (a == 1'b0) mMask = d;
  endtask

  task automatic bitOp(logic setIt, int idx);
    bitOpEn = 1'b1; bitOpSet = setIt; bitOpIdx = 5'(idx);
    tick(1);
    bitOpEn = 1'b0;
    mMask[idx] = setIt;
  endtask

  task automatic readChk(string req, logic a, logic [N-1:0] exp);
    regAddr = a;
    @(negedge clk);
    chk(req, regRdData, exp);
    @(posedge clk); #1;
  endtask

  task automatic setLevel(logic [N-1:0] v);
    srcLevel = v;
    tick(3);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk("R10 reset valid", {31'd0, pickValid}, 0);
    chk("R10 reset irq", {31'd0, cpuIrq}, 0);
    chk("R10 reset mask", regRdData, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick(1);

    // R7 register port
    regWrite(1'b0, '1);
    readChk("R7 mask readback", 1'b0, '1);
    regWrite(1'b1, 32'h0);
    readChk("R7 status write ignored", 1'b0, '1);
    readChk("R7 status view", 1'b1, 0);
    @(negedge clk);
    chk("R2 no levels valid", {31'd0, pickValid}, 0);
    chk("R2 no levels irq", {31'd0, cpuIrq}, 0);
    @(posedge clk); #1;

    // R8 sync latency and R9 irq lag
    srcLevel = (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 20);
    regAddr = 1'b1;
    @(negedge clk);
    chk("R8 before edge", regRdData, 0);
    @(negedge clk);
    chk("R8 after one edge", regRdData, 0);
    @(negedge clk);
    chk("R8 after two edges", regRdData, srcLevel);
    chk("R9 irq still low", {31'd0, cpuIrq}, 0);
    chk("R1 valid with pending", {31'd0, pickValid}, 1);
    @(negedge clk);
    chk("R9 irq one cycle later", {31'd0, cpuIrq}, 1);
    @(posedge clk); #1;

    // R3 R4 R5 scan from pointer 0, ack masks
    takeOne(); takeOne(); takeOne();
    @(negedge clk);
    chk("R2 all acked valid", {31'd0, pickValid}, 0);
    chk("R9 irq lags drop", {31'd0, cpuIrq}, 1);
    @(negedge clk);
    chk("R9 irq dropped", {31'd0, cpuIrq}, 0);
    @(posedge clk); #1;
    readChk("R5 acked bits cleared", 1'b0, ~((32'd1 << 3) | (32'd1 << 7) | (32'd1 << 20)));

    // R4 take while idle leaves pointer at 21
    takeOne();

    // R3 wrap past 31
    regWrite(1'b0, '1);
    setLevel((32'd1 << 1) | (32'd1 << 5) | (32'd1 << 31) | (32'd1 << 20));
    takeOne(); takeOne(); takeOne(); takeOne();

    // R6 single-bit ops
    regWrite(1'b0, 32'h0);
    setLevel((32'd1 << 9) | (32'd1 << 10));
    bitOp(1'b1, 10);
    readChk("R6 set one bit", 1'b0, 32'd1 << 10);
    takeOne();
    bitOp(1'b1, 9);
    bitOp(1'b0, 12);
    readChk("R6 clear leaves others", 1'b0, 32'd1 << 9);
    regWrite(1'b0, '1);
    bitOp(1'b0, 4);
    readChk("R6 clear one bit", 1'b0, ~(32'd1 << 4));

    // R1 level without enable is not pending
    setLevel(32'd1 << 4);
    @(negedge clk);
    chk("R1 disabled not pending", {31'd0, pickValid}, 0);
    @(posedge clk); #1;
    bitOp(1'b1, 4);
    @(negedge clk);
    chk("R1 enabled pending", {31'd0, pickValid}, 1);
    chk("R1 offered index", {27'd0, pickIdx}, 4);
    @(posedge clk); #1;

    // R11 precedence: write, bit set and ack in one cycle
    expQ.push_back(4);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = '1;
    bitOpEn = 1'b1; bitOpSet = 1'b1; bitOpIdx = 5'd4;
    takeNext = 1'b1;
    tick(1);
    regWrEn = 1'b0; bitOpEn = 1'b0; takeNext = 1'b0;
    mMask = ~(32'd1 << 4); mPtr = 5;
    readChk("R11 ack wins", 1'b0, ~(32'd1 << 4));

    chk("R3 all expected picks seen", 32'(expQ.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule